// File: doc/BRIEF.md
# Rewindable Single-Clock FIFO

This block is a single-clock FIFO with one write port and one read port. Besides ordinary first-in, first-out traffic, it accepts a rewind command that returns the read side to physical address zero. Data already stored in memory can then be read a second time, while the write side carries on from where it stopped.

Two behaviours are chosen by inputs that are captured only while the synchronous reset is asserted. The first is the flag style. In standard style, `rd_flag` high means words are stored, and a read presents its word one cycle after the request. In look-ahead style, the head word is moved to `rd_data` without any request, and `rd_flag` high means that word is valid. The second is rewind latency. With zero latency, the flags reflect the rewound state straight after the rewind edge. With normal latency, both ports are stalled for one cycle before the flags reflect it.

`DEPTH` must be a power of two.

Top module: `rewind_fifo`

## Requirements
- R1: `fwft_sel` (1 = look-ahead, 0 = standard) and `rt_norm_sel` (1 = normal latency, 0 = zero latency) are captured while `rst` is high. Changing them after reset has no effect.
- R2: A word is stored only on a rising `clk` edge where `wr_en` is high and `full` is low. Consecutive stores use consecutive physical addresses, wrapping from DEPTH-1 to 0.
- R3: In standard style, `rd_flag` is high whenever at least one word is stored. An accepted `rd_en` places the oldest word on `rd_data` after the next edge. Words come out in write order.
- R4: In look-ahead style, the oldest word appears on `rd_data` with `rd_flag` high without any `rd_en`. An edge with `rd_en` high and `rd_flag` high consumes it.
- R5: `full` is high when DEPTH words are held in memory. Writes while `full` is high are ignored and overwrite nothing.
- R6: A read request while `rd_flag` is low is ignored. `rd_data` and the read position are unchanged.
- R7: A rewind sets the read address to 0 and leaves the write address unchanged. The next write after a rewind lands after the last word written before it.
- R8: After a rewind, occupancy equals the write address. If the write address is 0, occupancy is DEPTH when a write has ever been made to address DEPTH-1, and 0 otherwise. `full` clears when occupancy is below DEPTH.
- R9: With zero latency, `rd_flag` and `full` reflect the rewound occupancy immediately after the rewind edge.
- R10: With normal latency, during the cycle after the rewind edge `rd_flag` is low and `full` is high, and a write in that cycle is ignored. The flags reflect the rewound state one cycle later.
- R11: In look-ahead style, a rewind clears `rd_flag`. The word at address 0 is then presented automatically, with no `rd_en`.
- R12: When a rewind and a read request fall on the same edge, only the rewind takes effect. No word is consumed and `rd_data` is unchanged.
- R13: After reset, `rd_flag` is low, `full` is low and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous master reset, active high; mode inputs are captured while it is high |
| fwft_sel | input | 1 | Flag style select, captured at reset (1 = look-ahead) |
| rt_norm_sel | input | 1 | Rewind latency select, captured at reset (1 = normal) |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read request |
| rewind | input | 1 | Rewind the read side to address 0 |
| rd_data | output | WIDTH | Read data register |
| rd_flag | output | 1 | Standard: words stored; look-ahead: `rd_data` valid |
| full | output | 1 | Memory full, or stall cycle after a normal-latency rewind |

## Verification
Inputs are applied 2 ns after a rising edge and take effect at the following edge. Flag checks are taken 2 ns after that edge, never at the edge itself.

In standard style, a read word is due on `rd_data` one edge after the accepted request. The scoreboard therefore marks the request at the falling edge and compares at the next falling edge. In look-ahead style, the word is compared at the falling edge of the cycle in which it is consumed.

A zero-latency rewind is checked one edge after the command. A normal-latency rewind is checked after one edge for the stall values and after two edges for the settled flags. The look-ahead re-presentation of address 0 is checked two edges after the rewind.

// File: rtl/rewind_fifo.sv
module rewind_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fwft_sel,
  input  logic             rt_norm_sel,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic             rewind,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_flag,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic             fwft_q, norm_q;
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             ov, hold, wrapped;

  wire          wr_ok   = wr_en && !full;
  wire [AW-1:0] wp_nx   = wp + AW'(wr_ok);
  wire          wrap_nx = wrapped | (wr_ok && wp == AW'(DEPTH - 1));
  wire [CW-1:0] rcnt    = (wp_nx != '0) ? CW'(wp_nx) : (wrap_nx ? CW'(DEPTH) : '0);
  wire          has     = cnt != '0;
  wire          std_pop = !fwft_q && rd_en && has && !hold;
  wire          fw_pop  = fwft_q && has && !hold && (!ov || rd_en);
  wire          pop     = !rewind && (std_pop || fw_pop);

  assign rd_flag = fwft_q ? ov : (has && !hold);
  assign full    = hold || cnt == CW'(DEPTH);

  always_ff @(posedge clk)
    if (rst) begin
      fwft_q <= fwft_sel;
      norm_q <= rt_norm_sel;
    end

  always_ff @(posedge clk)
    if (!rst && wr_ok) mem[wp] <= wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      ov      <= 1'b0;
      hold    <= 1'b0;
      wrapped <= 1'b0;
      rd_data <= '0;
    end else begin
      wp      <= wp_nx;
      wrapped <= wrap_nx;
      hold    <= rewind && norm_q;
      if (rewind) begin
        rp  <= '0;
        cnt <= rcnt;
        ov  <= 1'b0;
      end else begin
        cnt <= cnt + CW'(wr_ok) - CW'(pop);
        if (pop) begin
          rd_data <= mem[rp];
          rp      <= rp + 1'b1;
        end
        if (fwft_q) begin
          if (pop) ov <= 1'b1;
          else if (rd_en) ov <= 1'b0;
        end
      end
    end
  end
endmodule

module rewind_fifo_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       fwft_q,
  input logic                       norm_q,
  input logic                       rewind,
  input logic                       rd_flag,
  input logic                       full,
  input logic [$clog2(DEPTH)-1:0]   wp,
  input logic [$clog2(DEPTH)-1:0]   rp,
  input logic [$clog2(DEPTH):0]     cnt
);
  localparam int CW = $clog2(DEPTH) + 1;

  p_mode_kept_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(fwft_q) && $stable(norm_q)));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  p_full_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    full |=> $stable(wp));

  p_empty_read_r6: assert property (@(posedge clk) disable iff (rst)
    (!fwft_q && !rd_flag && !rewind) |=> $stable(rp));

  p_rewind_addr_r7: assert property (@(posedge clk) disable iff (rst)
    rewind |=> (rp == '0));

  p_norm_stall_r10: assert property (@(posedge clk) disable iff (rst)
    (rewind && norm_q) |=> (full && !rd_flag));

  p_fwft_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (rewind && fwft_q) |=> !rd_flag);
endmodule

bind rewind_fifo rewind_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .fwft_q(fwft_q), .norm_q(norm_q), .rewind(rewind),
  .rd_flag(rd_flag), .full(full), .wp(wp), .rp(rp), .cnt(cnt)
);

// File: tb/rewind_fifo_bench.sv
module rewind_fifo_bench;
  localparam int W = 8;
  localparam int D = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst = 1'b1, fwft_sel = 1'b0, rt_norm_sel = 1'b0;
  logic         wr_en = 1'b0, rd_en = 1'b0, rewind = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         rd_flag, full;

  rewind_fifo #(.WIDTH(W), .DEPTH(D)) u_rewind_fifo (
    .clk(clk), .rst(rst), .fwft_sel(fwft_sel), .rt_norm_sel(rt_norm_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rewind(rewind),
    .rd_data(rd_data), .rd_flag(rd_flag), .full(full)
  );

  int           checks = 0, fails = 0;
  logic [W-1:0] q[$];
  logic [W-1:0] bmem [D];
  int           bwp = 0;
  bit           bwrap = 0, fw_mode = 0, norm_mode = 0, hold_next = 0, pend = 0;
  string        sb_tag = "R3";

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (!fw_mode) begin
        if (pend) begin
          int e;
          pend = 0;
          e = (q.size() > 0) ? int'(q.pop_front()) : -1;
          chk(sb_tag, int'(rd_data), e);
        end
        if (rd_en && rd_flag && !rewind) pend = 1;
      end else if (rd_en && rd_flag && !rewind) begin
        int e;
        e = (q.size() > 0) ? int'(q.pop_front()) : -1;
        chk(sb_tag, int'(rd_data), e);
      end
    end
  end

  // driver
  task automatic step(bit w, logic [W-1:0] d, bit r, bit rw);
    @(posedge clk); #2;
    wr_en = w; wr_data = d; rd_en = r; rewind = rw;
    if (w && !hold_next && q.size() < D) begin
      bmem[bwp] = d;
      bwp = (bwp + 1) % D;
      if (bwp == 0) bwrap = 1;
      q.push_back(d);
    end
    hold_next = rw && norm_mode;
    if (rw) begin
      int n;
      n = (bwp != 0) ? bwp : (bwrap ? D : 0);
      q.delete();
      for (int i = 0; i < n; i++) q.push_back(bmem[i]);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic do_reset(bit fw, bit nm);
    @(posedge clk); #2;
    rst = 1'b1; fwft_sel = fw; rt_norm_sel = nm;
    wr_en = 0; rd_en = 0; rewind = 0;
    repeat (2) @(posedge clk);
    #2;
    rst = 1'b0; fw_mode = fw; norm_mode = nm;
    q.delete(); bwp = 0; bwrap = 0; hold_next = 0; pend = 0;
    fwft_sel = !fw; rt_norm_sel = !nm;   // R1: later changes must not matter
  endtask

  bit done = 0;

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // standard style, zero latency
    do_reset(1'b0, 1'b0);
    chk("R13 rd_flag", int'(rd_flag), 0);
    chk("R13 full", int'(full), 0);
    chk("R13 rd_data", int'(rd_data), 0);

    sb_tag = "R3";
    for (int i = 0; i < 3; i++) step(1'b1, W'(8'h10 + i), 1'b0, 1'b0);
    idle(1);
    chk("R3 rd_flag after writes", int'(rd_flag), 1);
    chk("R1 standard style kept, no preload", int'(rd_data), 0);
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, 1'b0);
    idle(2);
    chk("R3 rd_flag after drain", int'(rd_flag), 0);
    step(1'b0, '0, 1'b1, 1'b0);
    idle(2);
    chk("R6 rd_data after empty read", int'(rd_data), 8'h12);
    chk("R6 rd_flag after empty read", int'(rd_flag), 0);

    for (int i = 0; i < 10; i++) step(1'b1, W'(8'h40 + i), 1'b0, 1'b0);
    idle(1);
    chk("R5 full after overfill", int'(full), 1);
    chk("R2 rd_flag with data", int'(rd_flag), 1);

    step(1'b0, '0, 1'b1, 1'b1);
    idle(1);
    chk("R9 full cleared at once", int'(full), 0);
    chk("R9 rd_flag at once", int'(rd_flag), 1);
    chk("R12 rd_data unchanged", int'(rd_data), 8'h12);
    sb_tag = "R8";
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, 1'b0);
    idle(2);
    chk("R8 empty after three words", int'(rd_flag), 0);
    sb_tag = "R7";
    step(1'b1, 8'h77, 1'b0, 1'b0);
    idle(1);
    step(1'b0, '0, 1'b1, 1'b0);
    idle(2);
    chk("R7 empty after appended word", int'(rd_flag), 0);

    // standard style, normal latency
    do_reset(1'b0, 1'b1);
    step(1'b1, 8'h21, 1'b0, 1'b0);
    step(1'b1, 8'h22, 1'b0, 1'b0);
    idle(1);
    step(1'b0, '0, 1'b0, 1'b1);
    step(1'b1, 8'h99, 1'b0, 1'b0);
    chk("R10 stall rd_flag", int'(rd_flag), 0);
    chk("R10 stall full", int'(full), 1);
    idle(1);
    chk("R10 settled rd_flag", int'(rd_flag), 1);
    chk("R10 settled full", int'(full), 0);
    sb_tag = "R10";
    for (int i = 0; i < 2; i++) step(1'b0, '0, 1'b1, 1'b0);
    idle(2);
    chk("R10 stall write ignored", int'(rd_flag), 0);

    for (int i = 0; i < 6; i++) step(1'b1, W'(8'h30 + i), 1'b0, 1'b0);
    idle(1);
    chk("R5 not full at six", int'(full), 0);
    step(1'b0, '0, 1'b0, 1'b1);
    idle(2);
    chk("R8 full after wrapped rewind", int'(full), 1);
    chk("R8 rd_flag after wrapped rewind", int'(rd_flag), 1);
    sb_tag = "R8";
    for (int i = 0; i < 8; i++) step(1'b0, '0, 1'b1, 1'b0);
    idle(2);
    chk("R8 empty after full reread", int'(rd_flag), 0);

    // look-ahead style, zero latency
    do_reset(1'b1, 1'b0);
    chk("R13 look-ahead rd_flag", int'(rd_flag), 0);
    for (int i = 0; i < 3; i++) step(1'b1, W'(8'h51 + i), 1'b0, 1'b0);
    idle(2);
    chk("R4 head valid", int'(rd_flag), 1);
    chk("R1 R4 head preloaded", int'(rd_data), 8'h51);
    sb_tag = "R4";
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, 1'b0);
    idle(1);
    chk("R4 drained", int'(rd_flag), 0);
    step(1'b0, '0, 1'b0, 1'b1);
    idle(1);
    chk("R11 cleared by rewind", int'(rd_flag), 0);
    idle(1);
    chk("R11 address 0 presented", int'(rd_flag), 1);
    chk("R11 address 0 data", int'(rd_data), 8'h51);
    sb_tag = "R11";
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, 1'b0);
    idle(2);
    chk("R11 drained again", int'(rd_flag), 0);
    chk("R11 queue used up", q.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule